// File: doc/BRIEF.md
# Exponential Code Mapper

This block turns a 10-bit linear converter code into a 16-bit unsigned value whose spacing grows exponentially with the code, close to 2^(n/64). Small codes map to small values with fine steps. Large codes cover the upper range with coarse steps. A control loop that needs fine resolution near zero and wide range at the top can use the code as its setting directly.

The code splits into two fields. The upper four bits are a segment exponent and the lower six bits index into a segment. In table mode, a 64-entry constant table of fractional powers of two, scaled to 16 bits, is looked up by the index and shifted right so the segment exponent sets the magnitude. In linear mode, each segment instead runs as a straight line from one power of two towards the next. The slope is built from two shifts and one narrow multiply, and a per-transfer shift split selects how the precision is shared between the step and the offset.

The pipeline has two stages with a valid flag that travels alongside the data. Mode and shift split are sampled together with each code, so consecutive transfers may use different settings.

Top module: `exp_map`

## Requirements
- R1: While reset is asserted and after its release, until a result emerges, out_valid is 0 and out_value is 0.
- R2: For a code n, the segment exponent e is n[9:6] (n divided by 64) and the index f is n[5:0] (n modulo 64).
- R3: Table entry k (0 to 63) equals 32768 * 2^(k/64) rounded to the nearest integer, so entry 0 is 32768; with e = 15 the table entry appears unshifted at the output.
- R4: With in_mode = 0 (table mode), out_value is table entry f shifted right by 15 - e.
- R5: With in_mode = 1 (linear mode), out_value is 2^e + ((2^e >> r) * (f >> (6 - r))), where r is the shift split.
- R6: The shift split r is in_rshift when in_rshift is 6 or less; the value 7 acts as 6.
- R7: Each transfer with in_valid = 1 produces out_valid = 1 exactly two rising edges later, and out_valid is never raised otherwise; when no result emerges, out_value holds its last value.
- R8: In table mode, out_value does not decrease as the code increases over 0 to 1023.
- R9: In both modes, every result lies in [2^e, 2^(e+1)), so out_value >> e equals 1.
- R10: in_mode and in_rshift are taken per transfer, so back-to-back transfers with different settings each follow their own setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the code and settings this cycle |
| in_code | input | 10 | Linear code n |
| in_mode | input | 1 | 0 selects table mode, 1 selects linear mode |
| in_rshift | input | 3 | Linear-mode shift split r; 7 acts as 6 |
| out_valid | output | 1 | Result is present on out_value |
| out_value | output | 16 | Exponentially spaced result |

## Verification
The sweeps go after the segment seams, the 63-to-0 index wrap, where a wrong shift count or a misplaced field split would make the output step down or double. The top exponent 15 exposes the table entries unshifted, so a single wrong rounding constant shows up directly. Sweeping all eight shift splits in linear mode catches an unclamped split of 7, which would shift the offset by a negative amount and produce garbage. Interleaving modes on consecutive beats catches settings that are sampled once instead of per transfer, and an isolated transfer checks that a result arrives after exactly two edges and then holds.

// File: rtl/exp_map_pkg.sv
`timescale 1ns/1ps
package exp_map_pkg;
  localparam int CODE_W_D = 10;
  localparam int FRAC_W_D = 6;
  localparam int OUT_W_D  = 16;
  localparam int RS_W_D   = 3;

  typedef enum logic {
    MAP_TABLE  = 1'b0,
    MAP_LINEAR = 1'b1
  } map_mode_e;

  // Elaboration-time value of one fractional power: 2^(out_w-1) * 2^(k/2^frac_w), rounded.
  function automatic int frac_power(int k, int frac_w, int out_w);
    real scale;
    real ratio;
    scale = 2.0 ** (out_w - 1);
    ratio = 2.0 ** (real'(k) / real'(1 << frac_w));
    return $rtoi(scale * ratio + 0.5);
  endfunction
endpackage

// File: rtl/exp_frac_rom.sv
`timescale 1ns/1ps
module exp_frac_rom
  import exp_map_pkg::*;
#(
  parameter int FRAC_W = FRAC_W_D,
  parameter int OUT_W  = OUT_W_D
) (
  input  logic [FRAC_W-1:0] idx,
  output logic [OUT_W-1:0]  entry
);
  localparam int N_ENT = 1 << FRAC_W;

  logic [OUT_W-1:0] rom [N_ENT];

  generate
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
      localparam logic [OUT_W-1:0] ENT_VAL = OUT_W'(frac_power(k, FRAC_W, OUT_W));
      assign rom[k] = ENT_VAL;
    end
  endgenerate

  assign entry = rom[idx];

  // R3: every entry lies in [2^(OUT_W-1), 2^OUT_W)
  always_comb begin
    p_entry_msb_r3: assert (entry[OUT_W-1] == 1'b1);
  end
endmodule

// File: rtl/exp_map_decode.sv
`timescale 1ns/1ps
module exp_map_decode
  import exp_map_pkg::*;
#(
  parameter int CODE_W = CODE_W_D,
  parameter int FRAC_W = FRAC_W_D,
  parameter int OUT_W  = OUT_W_D,
  parameter int RS_W   = RS_W_D
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [CODE_W-1:0]          in_code,
  input  map_mode_e                  in_mode,
  input  logic [RS_W-1:0]            in_rs,
  output logic                       s1_valid,
  output map_mode_e                  s1_mode,
  output logic [CODE_W-FRAC_W-1:0]   s1_exp,
  output logic [FRAC_W-1:0]          s1_off,
  output logic [OUT_W-1:0]           s1_entry,
  output logic [RS_W-1:0]            s1_rs
);
  localparam int EXP_W  = CODE_W - FRAC_W;
  localparam int RS_MAX = FRAC_W;

  logic [EXP_W-1:0]  code_exp;
  logic [FRAC_W-1:0] code_off;
  logic [OUT_W-1:0]  rom_entry;
  logic [RS_W-1:0]   rs_clamped;

  assign code_exp   = in_code[CODE_W-1:FRAC_W];
  assign code_off   = in_code[FRAC_W-1:0];
  assign rs_clamped = (in_rs > RS_W'(RS_MAX)) ? RS_W'(RS_MAX) : in_rs;

  exp_frac_rom #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rom (
    .idx   (code_off),
    .entry (rom_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= MAP_TABLE;
      s1_exp   <= '0;
      s1_off   <= '0;
      s1_entry <= '0;
      s1_rs    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode  <= in_mode;
        s1_exp   <= code_exp;
        s1_off   <= code_off;
        s1_entry <= rom_entry;
        s1_rs    <= rs_clamped;
      end
    end
  end

  // R2: the registered fields put back together give the sampled code
  p_code_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ({s1_exp, s1_off} == $past(in_code)));

  // R6: the split handed to the scale stage never exceeds the field width
  p_rs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_rs <= RS_W'(RS_MAX)));

  // R10: the mode follows the transfer it came with
  p_mode_per_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_mode == $past(in_mode)));
endmodule

// File: rtl/exp_map_scale.sv
`timescale 1ns/1ps
module exp_map_scale
  import exp_map_pkg::*;
#(
  parameter int CODE_W = CODE_W_D,
  parameter int FRAC_W = FRAC_W_D,
  parameter int OUT_W  = OUT_W_D,
  parameter int RS_W   = RS_W_D
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_valid,
  input  map_mode_e                  s1_mode,
  input  logic [CODE_W-FRAC_W-1:0]   s1_exp,
  input  logic [FRAC_W-1:0]          s1_off,
  input  logic [OUT_W-1:0]           s1_entry,
  input  logic [RS_W-1:0]            s1_rs,
  output logic                       out_valid,
  output logic [OUT_W-1:0]           out_value
);
  localparam int EXP_W  = CODE_W - FRAC_W;
  localparam int TOP_SH = OUT_W - 1;
  localparam int WIDE   = OUT_W + 1;
  localparam int PROD_W = WIDE + FRAC_W;

  function automatic logic [OUT_W-1:0] table_value(logic [OUT_W-1:0] ent,
                                                   logic [EXP_W-1:0] e);
    return ent >> (TOP_SH - int'(e));
  endfunction

  function automatic logic [OUT_W-1:0] linear_value(logic [EXP_W-1:0]  e,
                                                    logic [FRAC_W-1:0] off,
                                                    logic [RS_W-1:0]   rs);
    logic [WIDE-1:0]   pow2;
    logic [WIDE-1:0]   step;
    logic [FRAC_W-1:0] part;
    logic [PROD_W-1:0] sum;
    pow2 = WIDE'(1) << e;
    step = pow2 >> rs;
    part = off >> (FRAC_W - int'(rs));
    sum  = PROD_W'(step) * PROD_W'(part) + PROD_W'(pow2);
    return sum[OUT_W-1:0];
  endfunction

  logic [OUT_W-1:0] tbl_res;
  logic [OUT_W-1:0] lin_res;
  logic [OUT_W-1:0] next_value;

  assign tbl_res    = table_value(s1_entry, s1_exp);
  assign lin_res    = linear_value(s1_exp, s1_off, s1_rs);
  assign next_value = (s1_mode == MAP_LINEAR) ? lin_res : tbl_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_value <= next_value;
    end
  end

  // R9: every result sits inside its own power-of-two segment
  p_segment_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> ((out_value >> $past(s1_exp)) == OUT_W'(1)));

  // R7: with nothing arriving, the output value holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_value));
endmodule

// File: rtl/exp_map.sv
`timescale 1ns/1ps
module exp_map
  import exp_map_pkg::*;
#(
  parameter int CODE_W = CODE_W_D,
  parameter int FRAC_W = FRAC_W_D,
  parameter int OUT_W  = OUT_W_D,
  parameter int RS_W   = RS_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_mode,
  input  logic [RS_W-1:0]   in_rshift,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_value
);
  localparam int EXP_W = CODE_W - FRAC_W;

  map_mode_e         mode_in;
  logic              s1_valid;
  map_mode_e         s1_mode;
  logic [EXP_W-1:0]  s1_exp;
  logic [FRAC_W-1:0] s1_off;
  logic [OUT_W-1:0]  s1_entry;
  logic [RS_W-1:0]   s1_rs;

  assign mode_in = map_mode_e'(in_mode);

  exp_map_decode #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .RS_W(RS_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_code  (in_code),
    .in_mode  (mode_in),
    .in_rs    (in_rshift),
    .s1_valid (s1_valid),
    .s1_mode  (s1_mode),
    .s1_exp   (s1_exp),
    .s1_off   (s1_off),
    .s1_entry (s1_entry),
    .s1_rs    (s1_rs)
  );

  exp_map_scale #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .RS_W(RS_W)) u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_mode   (s1_mode),
    .s1_exp    (s1_exp),
    .s1_off    (s1_off),
    .s1_entry  (s1_entry),
    .s1_rs     (s1_rs),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  // R7: a transfer always comes out two edges later
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R7: no result without a transfer two edges earlier
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/exp_map_bench.sv
`timescale 1ns/1ps
module exp_map_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [9:0]  in_code;
  logic        in_mode;
  logic [2:0]  in_rshift;
  logic        out_valid;
  logic [15:0] out_value;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];
  int code_q[$];
  int mode_q[$];
  int rs_q[$];
  int tbl_seen[1024];
  bit done = 0;

  always #10 clk = ~clk;

  exp_map u_exp_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .in_mode   (in_mode),
    .in_rshift (in_rshift),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  function automatic int ref_entry(int k);
    real x;
    x = 32768.0 * (2.0 ** (k / 64.0));
    return $rtoi(x + 0.5);
  endfunction

  function automatic int ref_table(int n);
    return ref_entry(n % 64) / (1 << (15 - n / 64));
  endfunction

  function automatic int ref_linear(int n, int rs);
    int r;
    int p;
    r = (rs > 6) ? 6 : rs;
    p = 1 << (n / 64);
    return p + (p / (1 << r)) * ((n % 64) / (1 << (6 - r)));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(input int code, input int mode, input int rs);
    in_code   = 10'(code);
    in_mode   = mode[0];
    in_rshift = 3'(rs);
    in_valid  = 1'b1;
    exp_q.push_back(mode != 0 ? ref_linear(code, rs) : ref_table(code));
    code_q.push_back(code);
    mode_q.push_back(mode);
    rs_q.push_back(rs);
    @(negedge clk);
  endtask

  task automatic idle(input int cycles);
    in_valid = 1'b0;
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  // Scoreboard: compares every emerging result against the arithmetic model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 result without transfer", 1, 0);
      end else begin
        int ev;
        int c;
        int m;
        int r;
        ev = exp_q.pop_front();
        c  = code_q.pop_front();
        m  = mode_q.pop_front();
        r  = rs_q.pop_front();
        if (m == 0) begin
          check(int'(out_value) == ev, "R4 table mode value", int'(out_value), ev);
          if (c >= 960)
            check(int'(out_value) == ref_entry(c - 960), "R3 table entry at top segment",
                  int'(out_value), ref_entry(c - 960));
          tbl_seen[c] = int'(out_value);
        end else if (r == 7) begin
          check(int'(out_value) == ev, "R6 split 7 acts as 6", int'(out_value), ev);
        end else begin
          check(int'(out_value) == ev, "R5 linear mode value", int'(out_value), ev);
        end
        check((int'(out_value) >> (c / 64)) == 1, "R9 segment range (R2 split)",
              int'(out_value) >> (c / 64), 1);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int held;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_code   = '0;
    in_mode   = 1'b0;
    in_rshift = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(out_value == 16'd0, "R1 out_value in reset", int'(out_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after release", int'(out_valid), 0);

    // R7: isolated transfer timing and hold
    send(100, 0, 0);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 not yet after one edge", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 present after two edges", int'(out_valid), 1);
    held = ref_table(100);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 single-cycle valid", int'(out_valid), 0);
    idle(3);
    check(int'(out_value) == held, "R7 value holds while idle", int'(out_value), held);

    // R3 R4 R8: full table-mode sweep
    for (int n = 0; n < 1024; n++) send(n, 0, 0);
    idle(3);

    // R5 R6: every code under every split
    for (int r = 0; r < 8; r++)
      for (int n = 0; n < 1024; n++) send(n, 1, r);
    idle(3);

    // R10: settings change on every beat
    for (int i = 0; i < 512; i++) send((i * 37 + 5) % 1024, i % 2, i % 8);
    idle(4);
    check(exp_q.size() == 0, "R7 every transfer produced a result", exp_q.size(), 0);

    // R8: monotonic in table mode
    for (int c = 1; c < 1024; c++)
      check(tbl_seen[c] >= tbl_seen[c - 1], "R8 table output non-decreasing",
            tbl_seen[c], tbl_seen[c - 1]);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule